// File: doc/BRIEF.md
# Read-Activated Hardware Option Latches

This block keeps a bank of byte-wide configuration options for the peripherals of a controller. It fills the bank by watching the system read bus, not through register writes. Software first stores the wanted option codes in a reserved window of program storage. After each reset, it then reads every location in that window once. Each completed read that hits the window is observed by this block, and the returned byte is copied into the option latch that belongs to that address.

A subrange of eight locations inside the window is hard-wired. Those latches always present fixed values that come from a parameter, and reads of them have no effect. The latched bytes are presented as registered outputs. The port-speed bytes and the two supervision-mode bits are also brought out as named signals. After every reset, all options return to their defaults until software reads the window again.

Top module: `opt_snoop_bank`

## Requirements
- R1: While `rst` is high at a rising clock edge, every editable option byte takes its default at that edge. Byte 0 (address 0x00FFA0) becomes 0xF0, so port bits 1.0–1.3 are fast (0) and 1.4–1.7 are slow (1). Bytes 1–6 (0x00FFA1–0x00FFA6, ports 2–7) become 0xFF, all slow. Byte 7 (0x00FFA7) and all other editable bytes become 0x00.
- R2: When `rd_done` is high at a rising edge and `rd_addr` lies in 0x00FFA0–0x00FFB7 or 0x00FFC0–0x00FFC3, byte (`rd_addr` − 0x00FFA0) holds `rd_data` from that edge on. It sits at bits 8·k+7:8·k of `opt_bytes`.
- R3: A completed read whose address is outside 0x00FFA0–0x00FFC3 leaves every output unchanged. This includes addresses whose upper bits differ.
- R4: Bytes 24–31 (0x00FFB8–0x00FFBF) always show the fixed parameter, and reads there change nothing. With the default parameter 64'hC35A81007E24E718, byte 24+j equals bits 8·j+7:8·j of that value.
- R5: When `rd_done` is low, no output changes, whatever the address and data.
- R6: Repeated reads of one location leave the byte from the most recent read.
- R7: `port_slow` bits 8·p+7:8·p equal option byte p for p = 0..6 (1 = slow). `wdog_hw` is bit 0 and `clkmon_hw` is bit 1 of byte 7 (0 = software-controlled).
- R8: A read that updates one byte leaves all other bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_done | input | 1 | A read completes in this cycle |
| rd_addr | input | 24 | Address of the completing read |
| rd_data | input | 8 | Byte returned by the completing read |
| opt_bytes | output | 288 | All 36 option bytes, byte k at bits 8k+7:8k |
| port_slow | output | 56 | Port speed selects, 1 = slow |
| wdog_hw | output | 1 | Watchdog forced by hardware option |
| clkmon_hw | output | 1 | Clock monitor forced by hardware option |

## Verification
Every result is due one edge after its stimulus. A completing read, an idle cycle or a reset that is applied before rising edge n appears on the outputs after edge n. The driver applies stimulus at falling edges and tags each expected snapshot with the cycle in which it is due. The monitor compares a snapshot only at the falling edge of that cycle, so it never samples at the edge where the latches load. Because a snapshot of the whole bank is compared in every driven cycle, reads that must have no effect and idle cycles are checked on all 36 bytes.

// File: rtl/opt_pkg.sv
package opt_pkg;
  localparam int unsigned PORT_BYTES = 7;
  localparam int unsigned SUPV_IDX   = 7;

  typedef logic [7:0] opt_byte_t;

  // Default of an editable option byte selected by its window offset
  function automatic opt_byte_t dflt_byte(input int unsigned idx);
    if (idx == 0)               return 8'hF0;
    else if (idx < PORT_BYTES)  return 8'hFF;
    else                        return 8'h00;
  endfunction
endpackage

// File: rtl/opt_win_decode.sv
module opt_win_decode #(
  parameter int unsigned AW        = 24,
  parameter int unsigned WIN_BASE  = 'hFFA0,
  parameter int unsigned WIN_LAST  = 'hFFC3,
  parameter int unsigned FIX_FIRST = 'hFFB8,
  parameter int unsigned FIX_LAST  = 'hFFBF,
  parameter int unsigned IW        = 6
) (
  input  logic [AW-1:0] addr,
  output logic          editable,
  output logic [IW-1:0] idx
);
  logic [AW-1:0] off;
  logic          in_win;
  logic          in_fix;

  always_comb begin
    off      = addr - AW'(WIN_BASE);
    idx      = off[IW-1:0];
    in_win   = (addr >= AW'(WIN_BASE))  && (addr <= AW'(WIN_LAST));
    in_fix   = (addr >= AW'(FIX_FIRST)) && (addr <= AW'(FIX_LAST));
    editable = in_win && !in_fix;
  end
endmodule

// File: rtl/opt_latch_bank.sv
module opt_latch_bank #(
  parameter int unsigned NUM    = 36,
  parameter int unsigned IW     = 6,
  parameter int unsigned FIX_LO = 24,
  parameter int unsigned FIX_N  = 8,
  parameter logic [8*FIX_N-1:0] FIX_VALS = 64'hC35A81007E24E718
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [7:0]      wr_data,
  output logic [8*NUM-1:0] bytes_q
);
  import opt_pkg::*;

  localparam int unsigned FIX_HI = FIX_LO + FIX_N - 1;

  opt_byte_t q [NUM];

  function automatic logic is_fixed(input int unsigned i);
    return (i >= FIX_LO) && (i <= FIX_HI);
  endfunction

  function automatic opt_byte_t reset_val(input int unsigned i);
    if (is_fixed(i)) return FIX_VALS[8*(i-FIX_LO) +: 8];
    else             return dflt_byte(i);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int unsigned i = 0; i < NUM; i++) q[i] <= reset_val(i);
    end else if (wr_en && (int'(wr_idx) < NUM) && !is_fixed(int'(wr_idx))) begin
      q[wr_idx] <= wr_data;
    end
  end

  for (genvar g = 0; g < NUM; g++) begin : g_flat
    assign bytes_q[8*g +: 8] = q[g];
  end
endmodule

// File: rtl/opt_snoop_bank.sv
module opt_snoop_bank #(
  parameter int unsigned AW        = 24,
  parameter int unsigned WIN_BASE  = 'hFFA0,
  parameter int unsigned WIN_LAST  = 'hFFC3,
  parameter int unsigned FIX_FIRST = 'hFFB8,
  parameter int unsigned FIX_LAST  = 'hFFBF,
  parameter logic [8*(FIX_LAST-FIX_FIRST+1)-1:0] FIX_VALS = 64'hC35A81007E24E718,
  localparam int unsigned NUM      = WIN_LAST - WIN_BASE + 1,
  localparam int unsigned PB       = opt_pkg::PORT_BYTES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_done,
  input  logic [AW-1:0]    rd_addr,
  input  logic [7:0]       rd_data,
  output logic [8*NUM-1:0] opt_bytes,
  output logic [8*PB-1:0]  port_slow,
  output logic             wdog_hw,
  output logic             clkmon_hw
);
  localparam int unsigned IW     = $clog2(NUM);
  localparam int unsigned FIX_LO = FIX_FIRST - WIN_BASE;
  localparam int unsigned FIX_N  = FIX_LAST - FIX_FIRST + 1;
  localparam int unsigned SV     = opt_pkg::SUPV_IDX;

  logic          hit_edit;
  logic [IW-1:0] hit_idx;

  opt_win_decode #(
    .AW(AW), .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST),
    .FIX_FIRST(FIX_FIRST), .FIX_LAST(FIX_LAST), .IW(IW)
  ) u_dec (
    .addr(rd_addr), .editable(hit_edit), .idx(hit_idx)
  );

  opt_latch_bank #(
    .NUM(NUM), .IW(IW), .FIX_LO(FIX_LO), .FIX_N(FIX_N), .FIX_VALS(FIX_VALS)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(rd_done && hit_edit),
    .wr_idx(hit_idx), .wr_data(rd_data), .bytes_q(opt_bytes)
  );

  assign port_slow = opt_bytes[8*PB-1:0];
  assign wdog_hw   = opt_bytes[8*SV];
  assign clkmon_hw = opt_bytes[8*SV+1];
endmodule

// File: rtl/opt_snoop_chk.sv
module opt_snoop_chk #(
  parameter int unsigned AW        = 24,
  parameter int unsigned WIN_BASE  = 'hFFA0,
  parameter int unsigned WIN_LAST  = 'hFFC3,
  parameter int unsigned FIX_FIRST = 'hFFB8,
  parameter int unsigned FIX_LAST  = 'hFFBF,
  parameter logic [8*(FIX_LAST-FIX_FIRST+1)-1:0] FIX_VALS = 64'hC35A81007E24E718,
  parameter int unsigned NUM       = 36,
  parameter int unsigned PB        = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_done,
  input logic [AW-1:0]    rd_addr,
  input logic [7:0]       rd_data,
  input logic [8*NUM-1:0] opt_bytes,
  input logic [8*PB-1:0]  port_slow,
  input logic             wdog_hw,
  input logic             clkmon_hw
);
  logic in_win, in_fix;
  assign in_win = (rd_addr >= AW'(WIN_BASE))  && (rd_addr <= AW'(WIN_LAST));
  assign in_fix = (rd_addr >= AW'(FIX_FIRST)) && (rd_addr <= AW'(FIX_LAST));

  // R1: reset loads the port-speed defaults
  p_reset_dflt_r1: assert property (@(posedge clk)
    rst |=> (opt_bytes[7:0] == 8'hF0) && (opt_bytes[15:8] == 8'hFF) && (opt_bytes[63:56] == 8'h00));

  // R2: an editable read shows its data one edge later
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_done && in_win && !in_fix) |=>
      (opt_bytes[8*($past(rd_addr) - AW'(WIN_BASE)) +: 8] == $past(rd_data)));

  // R3: reads outside the window leave the bank alone
  p_outside_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_done && !in_win) |=> $stable(opt_bytes));

  // R4: reads of the hard-wired range leave the bank alone
  p_fixed_read_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_done && in_fix) |=> $stable(opt_bytes));

  // R4: the hard-wired bytes equal the parameter once out of reset
  p_fixed_val_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (opt_bytes[8*(FIX_FIRST-WIN_BASE) +: 8*(FIX_LAST-FIX_FIRST+1)] == FIX_VALS));

  // R5: no completing read, no change
  p_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_done |=> $stable(opt_bytes));

  // R7: named outputs follow the option bytes
  p_named_r7: assert property (@(posedge clk) disable iff (rst)
    (port_slow == opt_bytes[8*PB-1:0]) && (wdog_hw == opt_bytes[8*PB]) && (clkmon_hw == opt_bytes[8*PB+1]));
endmodule

bind opt_snoop_bank opt_snoop_chk #(
  .AW(AW), .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST),
  .FIX_FIRST(FIX_FIRST), .FIX_LAST(FIX_LAST), .FIX_VALS(FIX_VALS),
  .NUM(NUM), .PB(PB)
) u_chk (
  .clk(clk), .rst(rst), .rd_done(rd_done), .rd_addr(rd_addr), .rd_data(rd_data),
  .opt_bytes(opt_bytes), .port_slow(port_slow), .wdog_hw(wdog_hw), .clkmon_hw(clkmon_hw)
);

// File: tb/sim_opt_snoop_bank.sv
module sim_opt_snoop_bank;
  localparam int NB = 36;
  localparam logic [63:0] FIXV = 64'hC35A81007E24E718;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_done = 1'b0;
  logic [23:0]   rd_addr = '0;
  logic [7:0]    rd_data = '0;
  logic [8*NB-1:0] opt_bytes;
  logic [55:0]   port_slow;
  logic          wdog_hw, clkmon_hw;

  opt_snoop_bank u0 (
    .clk(clk), .rst(rst), .rd_done(rd_done), .rd_addr(rd_addr), .rd_data(rd_data),
    .opt_bytes(opt_bytes), .port_slow(port_slow), .wdog_hw(wdog_hw), .clkmon_hw(clkmon_hw)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int              due;
    logic [8*NB-1:0] flat;
    string           tag;
  } item_t;

  item_t      sbq[$];
  logic [7:0] mdl [NB];
  int         cyc = 0;
  int         total = 0;
  int         bad = 0;
  bit         done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [8*NB-1:0] snap();
    logic [8*NB-1:0] f;
    for (int i = 0; i < NB; i++) f[8*i +: 8] = mdl[i];
    return f;
  endfunction

  function automatic void mdl_reset();
    for (int i = 0; i < NB; i++) mdl[i] = 8'h00;
    mdl[0] = 8'hF0;
    for (int i = 1; i < 7; i++) mdl[i] = 8'hFF;
    for (int j = 0; j < 8; j++) mdl[24+j] = FIXV[8*j +: 8];
  endfunction

  task automatic push(input string tag);
    item_t it;
    it.due = cyc + 1; it.flat = snap(); it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; rd_done = 1'b0;
    mdl_reset();
    push(tag);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    rst = 1'b0; rd_done = 1'b1; rd_addr = a; rd_data = d;
    if (a >= 24'h00FFA0 && a <= 24'h00FFC3 && !(a >= 24'h00FFB8 && a <= 24'h00FFBF))
      mdl[a - 24'h00FFA0] = d;
    push(tag);
  endtask

  task automatic idle(input logic [23:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    rd_done = 1'b0; rd_addr = a; rd_data = d;
    push(tag);
  endtask

  // Monitor: compares each expected snapshot in the cycle it is due
  initial begin
    forever begin
      @(negedge clk);
      while (sbq.size() > 0 && sbq[0].due == cyc) begin
        item_t it;
        it = sbq.pop_front();
        total++;
        if (opt_bytes !== it.flat) begin
          bad++;
          $display("FAIL %s: opt_bytes act=%h exp=%h", it.tag, opt_bytes, it.flat);
        end
        total++;
        if (port_slow !== it.flat[55:0] || wdog_hw !== it.flat[56] || clkmon_hw !== it.flat[57]) begin
          bad++;
          $display("FAIL R7 (%s): named act=%h/%b/%b exp=%h/%b/%b", it.tag,
                   port_slow, wdog_hw, clkmon_hw, it.flat[55:0], it.flat[56], it.flat[57]);
        end
      end
    end
  end

  initial begin
    do_reset("R1 reset defaults");
    rd(24'h00FFA0, 8'h0F, "R2 first byte");
    rd(24'h00FFC3, 8'hA5, "R2 last byte");
    rd(24'h00FFB7, 8'h3C, "R2 below fixed");
    rd(24'h00FFC0, 8'h66, "R2 above fixed");
    rd(24'h00FFA3, 8'h5A, "R8 single byte changes");
    rd(24'h00FFB8, 8'h00, "R4 fixed first");
    rd(24'h00FFBF, 8'h11, "R4 fixed last");
    rd(24'h00FFBB, 8'hEE, "R4 fixed middle");
    rd(24'h00FF9F, 8'h77, "R3 below window");
    rd(24'h00FFC4, 8'h77, "R3 above window");
    rd(24'h01FFA5, 8'h77, "R3 upper bits differ");
    idle(24'h00FFA1, 8'h99, "R5 idle in window");
    idle(24'h00FFA7, 8'h03, "R5 idle supervision");
    rd(24'h00FFA7, 8'h01, "R6 R7 watchdog hw");
    rd(24'h00FFA7, 8'h02, "R6 R7 clock monitor overwrite");
    rd(24'h00FFA7, 8'h03, "R6 latest value");
    for (int k = 0; k < 7; k++) rd(24'h00FFA0 + 24'(k), 8'(8'h11 * k), "R7 port bytes");
    idle(24'h000000, 8'h00, "R5 quiet");
    do_reset("R1 reset restores defaults");
    idle(24'h00FFA0, 8'h00, "R1 defaults held");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 100000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: act=timeout exp=finish");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule